// File: doc/BRIEF.md
# Inter-Core Mailbox Bank

This block stores a set of 32-bit mailboxes that cores use to signal one another. Every core owns four mailboxes. The bank sits behind a single 32-bit register port that handles one access per cycle. The same storage is reached through two address windows. A write to the *set* window ORs the written data into a mailbox, so separate senders can post independent flag bits without a read-modify-write. A write to the *clear* window removes exactly the bits that are 1 in the data. Reads through the clear window return the mailbox contents.

A mailbox raises a request whenever any of its bits is nonzero. Each core has an 8-bit steering register that decides how each of its four mailboxes is delivered:
- bits 3:0 enable the normal request (IRQ) for slots 0 to 3;
- bits 7:4 enable the fast request (FIQ) for the same slots.

When both are enabled, the fast request wins. The block drives flat request vectors, one bit per mailbox. A downstream router merges these vectors with the other interrupt sources of each core.

Top module: `mbox_bank`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every mailbox and every steering register. After reset, irq_req and fiq_req are all zero and every read returns 0.
- R2: An accepted write at byte address 0x80 + 4·i (i = 0..15) ORs wdata into mailbox i. Bits that were already set stay set.
- R3: An accepted write at byte address 0xC0 + 4·i clears the bits of mailbox i where wdata is 1. All other bits are left as they were.
- R4: An accepted read at 0xC0 + 4·i returns mailbox i on rdata, valid from the clock edge that samples the request. A read in the set window (0x80 to 0xBF) returns 0.
- R5: The steering register of core c sits at 0x50 + 4·c (c = 0..3). A write keeps wdata[7:0] and drops the higher bits. A read returns the stored 8 bits zero-extended.
- R6: Mailbox i belongs to core i/4, slot i%4. Request bit i is asserted only while mailbox i is nonzero. fiq_req[i] = 1 exactly when the mailbox is nonzero and bit (4 + i%4) of core i/4's steering register is 1.
- R7: irq_req[i] = 1 exactly when mailbox i is nonzero, bit (i%4) of its core's steering register is 1, and bit (4 + i%4) is 0. The fast enable takes priority, so irq_req[i] and fiq_req[i] are never both 1.
- R8: An access is accepted only if be = 4'hF and addr[1:0] = 0. Any other write changes no state. Any other read returns 0.
- R9: A read has no side effect. Reading a mailbox leaves its value unchanged.
- R10: A write to an address outside the steering, set and clear windows changes no state. A read there returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| be | input | 4 | Byte enables; must be all ones for the access to be accepted |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, updated on each read |
| irq_req | output | 16 | Normal request per mailbox, bit index = 4·core + slot |
| fiq_req | output | 16 | Fast request per mailbox, bit index = 4·core + slot |

## Verification
The set and clear windows are tried with overlapping and disjoint bit patterns on the same mailbox. This shows whether OR-accumulation, selective clearing and read-without-clear are each done right. Steering is tried with the IRQ enable alone, the FIQ enable alone, both enables together, and neither enable. This distinguishes correct priority from a simple OR of the enables. A request is also cleared through the clear window, showing that it follows the mailbox value and is not latched. Partial-width, unaligned and out-of-window accesses are checked for no effect by reading back the contents they could have disturbed.

// File: rtl/mbox_bank_pkg.sv
// Package: shared sizes, address map and read-source type for the mailbox bank.
// Assumes a byte-addressed 32-bit register port with word-aligned registers.
package mbox_bank_pkg;
    localparam int CORES      = 4;
    localparam int SLOTS      = 4;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int BE_W       = DATA_W / 8;
    localparam int N_MBOX     = CORES * SLOTS;
    localparam int CTL_W      = 2 * SLOTS;
    localparam int CTL_BASE   = 'h50;
    localparam int SET_BASE   = 'h80;
    localparam int CLR_BASE   = SET_BASE + 4 * N_MBOX;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_MBOX = 2'd1,
        RD_CTRL = 2'd2
    } rd_kind_e;
endpackage

// File: rtl/mbox_decode.sv
// Module: address decoder for the mailbox bank.
// Turns one bus access into one-hot write strobes and a read source.
// Assumes the windows do not overlap. Rejects partial-width or unaligned
// accesses, and addresses outside the windows.
module mbox_decode
    import mbox_bank_pkg::*;
#(
    parameter int A_W     = ADDR_W,
    parameter int NB      = BE_W,
    parameter int NMB     = N_MBOX,
    parameter int NCORE   = CORES,
    parameter int B_CTL   = CTL_BASE,
    parameter int B_SET   = SET_BASE,
    parameter int B_CLR   = CLR_BASE,
    localparam int IDX_W  = $clog2(NMB)
) (
    input  logic             req,
    input  logic             we,
    input  logic [NB-1:0]    be,
    input  logic [A_W-1:0]   addr,
    output logic [NMB-1:0]   set_hit,
    output logic [NMB-1:0]   clr_hit,
    output logic [NCORE-1:0] ctl_hit,
    output rd_kind_e         rd_kind,
    output logic [IDX_W-1:0] rd_idx
);
    localparam int SET_END = B_SET + 4 * NMB;
    localparam int CLR_END = B_CLR + 4 * NMB;
    localparam int CTL_END = B_CTL + 4 * NCORE;

    logic ok;
    int   a;
    logic in_set, in_clr, in_ctl;
    logic [IDX_W-1:0] set_idx, clr_idx, ctl_idx;

    // Classify the address and compute the word index inside each window.
    always_comb begin
        ok      = req && (&be) && (addr[1:0] == 2'b00);
        a       = int'(addr);
        in_set  = (a >= B_SET) && (a < SET_END);
        in_clr  = (a >= B_CLR) && (a < CLR_END);
        in_ctl  = (a >= B_CTL) && (a < CTL_END);
        set_idx = IDX_W'((a - B_SET) >> 2);
        clr_idx = IDX_W'((a - B_CLR) >> 2);
        ctl_idx = IDX_W'((a - B_CTL) >> 2);
    end

    // Produce one-hot write strobes for accepted writes.
    always_comb begin
        set_hit = '0;
        clr_hit = '0;
        ctl_hit = '0;
        if (ok && we) begin
            for (int i = 0; i < NMB; i++) begin
                set_hit[i] = in_set && (set_idx == IDX_W'(i));
                clr_hit[i] = in_clr && (clr_idx == IDX_W'(i));
            end
            for (int c = 0; c < NCORE; c++) begin
                ctl_hit[c] = in_ctl && (ctl_idx == IDX_W'(c));
            end
        end
    end

    // Select the read source; the set window and stray addresses read as zero.
    always_comb begin
        rd_kind = RD_NONE;
        rd_idx  = '0;
        if (ok && !we) begin
            if (in_clr) begin
                rd_kind = RD_MBOX;
                rd_idx  = clr_idx;
            end else if (in_ctl) begin
                rd_kind = RD_CTRL;
                rd_idx  = ctl_idx;
            end
        end
    end
endmodule

// File: rtl/mbox_slot.sv
// Module: one mailbox word with OR-set and bit-clear updates.
// Assumes set and clear are never strobed together (single port).
module mbox_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output logic         pend
);
    // Hold the mailbox word: accumulate on set, knock out bits on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (set_en)
            q <= q | wdata;
        else if (clr_en)
            q <= q & ~wdata;
    end

    // Pending while any bit is set.
    assign pend = |q;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (q == '0));
    assert_set_bits_land_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(wdata)) == $past(wdata)));
    assert_set_keeps_old_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(q)) == $past(q)));
    assert_clear_bits_gone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((q & $past(wdata)) == '0));
    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/mbox_steer.sv
// Module: per-core delivery steering for that core's mailboxes.
// Low half of ctl enables normal requests, high half enables fast requests.
// A fast enable masks the normal request for the same slot.
module mbox_steer #(
    parameter int S = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [S-1:0]   pend,
    input  logic [2*S-1:0] ctl,
    output logic [S-1:0]   irq_o,
    output logic [S-1:0]   fiq_o
);
    logic [S-1:0] irq_en, fiq_en;

    // Split the steering byte into its two enable halves.
    assign irq_en = ctl[S-1:0];
    assign fiq_en = ctl[2*S-1:S];

    // Route each pending slot to fast or normal delivery, fast first.
    always_comb begin
        fiq_o = pend & fiq_en;
        irq_o = pend & irq_en & ~fiq_en;
    end

    assert_no_dual_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & fiq_o) == '0));
    assert_request_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (((irq_o | fiq_o) & ~pend) == '0));
endmodule

// File: rtl/mbox_bank.sv
// Module: top of the inter-core mailbox bank.
// Holds per-core steering registers, the mailbox words and a registered
// read port. Drives flat request vectors indexed as core*SLOTS + slot.
// Assumes one bus access per cycle; only full-width aligned accesses count.
module mbox_bank
    import mbox_bank_pkg::*;
#(
    parameter int NUM_CORES = CORES,
    parameter int NUM_SLOTS = SLOTS,
    parameter int DW        = DATA_W,
    parameter int AW        = ADDR_W,
    localparam int NB       = DW / 8,
    localparam int NMB      = NUM_CORES * NUM_SLOTS,
    localparam int CW       = 2 * NUM_SLOTS,
    localparam int IDX_W    = $clog2(NMB),
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic           we,
    input  logic [NB-1:0]  be,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [NMB-1:0] irq_req,
    output logic [NMB-1:0] fiq_req
);
    logic [NMB-1:0]       set_hit, clr_hit, pend;
    logic [NUM_CORES-1:0] ctl_hit;
    rd_kind_e             rd_kind;
    logic [IDX_W-1:0]     rd_idx;
    logic [DW-1:0]        mbox_q [NMB];
    logic [CW-1:0]        ctl_q  [NUM_CORES];
    logic [DW-1:0]        rd_val;

    mbox_decode #(
        .A_W(AW), .NB(NB), .NMB(NMB), .NCORE(NUM_CORES),
        .B_CTL(CTL_BASE), .B_SET(SET_BASE), .B_CLR(SET_BASE + 4 * NMB)
    ) u_dec (
        .req(req), .we(we), .be(be), .addr(addr),
        .set_hit(set_hit), .clr_hit(clr_hit), .ctl_hit(ctl_hit),
        .rd_kind(rd_kind), .rd_idx(rd_idx)
    );

    for (genvar i = 0; i < NMB; i++) begin : g_mbox
        mbox_slot #(.W(DW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .set_en(set_hit[i]), .clr_en(clr_hit[i]),
            .wdata(wdata), .q(mbox_q[i]), .pend(pend[i])
        );
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        // Steering register of core c: keep only the low CW bits of a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctl_q[c] <= '0;
            else if (ctl_hit[c])
                ctl_q[c] <= wdata[CW-1:0];
        end

        mbox_steer #(.S(NUM_SLOTS)) u_steer (
            .clk(clk), .rst_n(rst_n),
            .pend(pend[c*NUM_SLOTS +: NUM_SLOTS]),
            .ctl(ctl_q[c]),
            .irq_o(irq_req[c*NUM_SLOTS +: NUM_SLOTS]),
            .fiq_o(fiq_req[c*NUM_SLOTS +: NUM_SLOTS])
        );

        assert_ctl_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_hit[c] |=> $stable(ctl_q[c]));
    end

    // Pick the word a read returns.
    always_comb begin
        case (rd_kind)
            RD_MBOX: rd_val = mbox_q[rd_idx];
            RD_CTRL: rd_val = DW'(ctl_q[rd_idx[CORE_W-1:0]]);
            default: rd_val = '0;
        endcase
    end

    // Register read data on every read request; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (req && !we)
            rdata <= rd_val;
    end

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_hit, clr_hit, ctl_hit}));
    assert_partial_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && (be != '1)) |-> ((set_hit == '0) && (clr_hit == '0) && (ctl_hit == '0)));
    assert_rejected_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && (be != '1)) |=> (rdata == '0));
endmodule

// File: tb/mbox_bank_tb.sv
module mbox_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  rq;
    } vec_t;

    // Table: writes, then reads checked against exp (rq = requirement number).
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h80, 32'h0000_00F0, 32'h0, 4'd2},  // R2 first set
        '{1'b1, 8'h80, 32'h0000_0F00, 32'h0, 4'd2},  // R2 OR in more bits
        '{1'b0, 8'hC0, 32'h0,         32'h0000_0FF0, 4'd2},
        '{1'b1, 8'hC0, 32'h0000_0030, 32'h0, 4'd3},  // R3 clear two bits
        '{1'b0, 8'hC0, 32'h0,         32'h0000_0FC0, 4'd3},
        '{1'b0, 8'hC0, 32'h0,         32'h0000_0FC0, 4'd9},  // R9 read again
        '{1'b1, 8'hBC, 32'hA5A5_0001, 32'h0, 4'd2},  // last mailbox
        '{1'b0, 8'hFC, 32'h0,         32'hA5A5_0001, 4'd4},
        '{1'b0, 8'hBC, 32'h0,         32'h0,         4'd4},  // R4 set window reads 0
        '{1'b0, 8'hC4, 32'h0,         32'h0,         4'd2},  // neighbour untouched
        '{1'b1, 8'h50, 32'hFFFF_FF3C, 32'h0, 4'd5},  // R5 high bits dropped
        '{1'b0, 8'h50, 32'h0,         32'h0000_003C, 4'd5},
        '{1'b1, 8'h5C, 32'h0000_0181, 32'h0, 4'd5},
        '{1'b0, 8'h5C, 32'h0,         32'h0000_0081, 4'd5},
        '{1'b1, 8'h44, 32'hFFFF_FFFF, 32'h0, 4'd10}, // R10 stray write
        '{1'b0, 8'h44, 32'h0,         32'h0,         4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  be = 4'hF;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] irq_req, fiq_req;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rv;

    mbox_bank u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .be(be),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_req(irq_req), .fiq_req(fiq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req   = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk);
        req = 1'b0; we = 1'b0; be = 4'hF;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] b = 4'hF);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a; be = b;
        @(negedge clk);
        req = 1'b0; be = 4'hF;
        d = rdata;
    endtask

    initial begin
        do_reset();

        // R1: reset state
        check("R1 irq after reset", {16'h0, irq_req}, 32'h0);
        check("R1 fiq after reset", {16'h0, fiq_req}, 32'h0);
        rd(8'hC0, rv); check("R1 mailbox after reset", rv, 32'h0);
        rd(8'h50, rv); check("R1 steer after reset", rv, 32'h0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            if (VEC[k].we) begin
                wr(VEC[k].addr, VEC[k].data);
            end else begin
                rd(VEC[k].addr, rv);
                check($sformatf("R%0d vec %0d", VEC[k].rq, k), rv, VEC[k].exp);
            end
        end

        // R1: reset mid-run wipes populated state
        do_reset();
        rd(8'hFC, rv); check("R1 mailbox wiped", rv, 32'h0);
        rd(8'h5C, rv); check("R1 steer wiped", rv, 32'h0);

        // R6/R7: steering on core 1 (mailboxes 4..7)
        wr(8'h54, 32'h0000_0021);   // IRQ slot0, FIQ slot1
        wr(8'h90, 32'h0000_0001);   // mailbox 4
        check("R7 irq only slot0", {16'h0, irq_req}, 32'h0010);
        check("R6 no fiq yet", {16'h0, fiq_req}, 32'h0000);
        wr(8'h94, 32'h0000_0002);   // mailbox 5
        check("R6 fiq slot1", {16'h0, fiq_req}, 32'h0020);
        check("R7 slot1 not on irq", {16'h0, irq_req}, 32'h0010);
        wr(8'h54, 32'h0000_0011);   // both enables on slot0, none on slot1
        check("R7 fiq wins", {16'h0, fiq_req}, 32'h0010);
        check("R7 irq masked", {16'h0, irq_req}, 32'h0000);
        wr(8'hD0, 32'h0000_0001);   // clear mailbox 4 fully
        check("R6 cleared mailbox drops", {16'h0, fiq_req}, 32'h0000);

        // R6: partial clear leaves request pending
        wr(8'h54, 32'h0000_0002);   // IRQ slot1
        wr(8'h94, 32'h0000_0004);   // mailbox 5 = 0x6
        wr(8'hD4, 32'h0000_0002);   // leave 0x4
        check("R6 partial clear still pending", {16'h0, irq_req}, 32'h0020);
        wr(8'hD4, 32'h0000_0004);
        check("R6 empty mailbox idle", {16'h0, irq_req}, 32'h0000);

        // R6: nonzero mailbox with no enables requests nothing
        wr(8'hA0, 32'h8000_0000);   // mailbox 8, core 2 steering zero
        check("R6 masked irq", {16'h0, irq_req}, 32'h0);
        check("R6 masked fiq", {16'h0, fiq_req}, 32'h0);

        // R8: partial-width and unaligned accesses ignored
        wr(8'h80, 32'h0000_00FF, 4'h3);
        rd(8'hC0, rv); check("R8 partial write ignored", rv, 32'h0);
        wr(8'h81, 32'h0000_00FF);
        rd(8'hC0, rv); check("R8 unaligned write ignored", rv, 32'h0);
        wr(8'hE0, 32'hFFFF_FFFF, 4'h1);
        rd(8'hE0, rv); check("R8 partial clear ignored", rv, 32'h8000_0000);
        rd(8'hE0, rv, 4'h7); check("R8 partial read zero", rv, 32'h0);
        wr(8'h58, 32'h0000_00F0, 4'hE);
        rd(8'h58, rv); check("R8 partial steer write ignored", rv, 32'h0);
        check("R8 no request from ignored steer", {16'h0, fiq_req}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule